// File: doc/BRIEF.md
# Interleaved-Leg Redundant State Selector

This block sits between a five-level phase modulator and the gate logic of two parallel three-level converter legs that share one phase. The modulator asks for a phase level between -2 and +2, where the phase output is the average of the two leg outputs. The selector turns that request into a state code for each leg. At the two intermediate levels, two leg combinations give the same phase voltage. The selector picks one of them from the sign of the circulating current, so that the current between the legs is pushed back towards zero.

The circulating current is taken as half the difference of the two leg currents. Its sign arrives as a single bit. A new combination is picked only when an accepted strobe changes the level, so the redundant pair is never toggled back and forth at a constant level. Each accepted step moves exactly one leg. A request that would skip a level, or that lies outside the five levels, is refused: the state stays as it is and a sticky error flag is raised. One instance serves one phase, and a three-phase system uses three instances that work independently.

Top module: `isel_leg_selector`

## Requirements
- R1: After a synchronous reset, both leg codes are 00, the level output is 0, the effect output is 00 and the error flag is 0.
- R2: Leg codes are 2 bits wide, with 01 = +1, 00 = 0 and 11 = -1. An accepted level +2 sets both legs to 01, and an accepted level -2 sets both legs to 11.
- R3: An accepted level 0 sets both legs to 00. The combinations with the legs at opposite extremes never appear.
- R4: For an accepted level +1, the legs become leg_a=00, leg_b=01 when icirc_neg is 0 (current positive or zero), and leg_a=01, leg_b=00 when icirc_neg is 1. For an accepted level -1, they become leg_a=11, leg_b=00 when icirc_neg is 0, and leg_a=00, leg_b=11 when icirc_neg is 1.
- R5: The effect output equals leg_a minus leg_b, as a 2-bit two's complement value (01 = +1, 00 = 0, 11 = -1). It is never 10.
- R6: A strobe that requests the current level changes no output, whatever the value of icirc_neg, and does not raise the error flag.
- R7: The level request is a 3-bit two's complement value. A strobed request that is outside -2..+2, or that differs from the current level by more than one, leaves the legs, the level and the effect unchanged and sets the error flag.
- R8: Once set, the error flag stays at 1 until reset, including after later legal steps. Those legal steps are still carried out.
- R9: While lvl_stb is 0, the request and sign inputs have no effect on any output.
- R10: All outputs are registered. The level output shows the last accepted level, and an accepted strobe becomes visible on the clock edge at which it is sampled. Each accepted step changes exactly one leg.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| lvl_req | input | 3 | Requested phase level, two's complement |
| lvl_stb | input | 1 | Request valid for this cycle |
| icirc_neg | input | 1 | 1 when the circulating current is negative |
| leg_a | output | 2 | State code of leg A |
| leg_b | output | 2 | State code of leg B |
| circ_eff | output | 2 | Effect of the present combination on the circulating current |
| lvl_out | output | 3 | Last accepted level, two's complement |
| step_err | output | 1 | Sticky refused-request flag |

## Verification
The hardest situations to reach from the ports are refused requests that start from an intermediate level that was entered with a particular redundant combination. The state held after the refusal depends on that earlier pick. For this reason the stimulus first resets the block and walks it, one legal step at a time, to each of the five start levels. At each start level it applies every 3-bit request with both sign values. After an error it adds a legal step to show that the flag stays set while the step is still carried out, and it adds an unstrobed request to show that the request is ignored.

// File: rtl/isel_pkg.sv
package isel_pkg;
  typedef logic [1:0] leg_code_t;
  localparam leg_code_t LEG_POS  = 2'b01;
  localparam leg_code_t LEG_ZERO = 2'b00;
  localparam leg_code_t LEG_NEG  = 2'b11;
endpackage

// File: rtl/isel_step_chk.sv
module isel_step_chk #(
  parameter int LVL_W   = 3,
  parameter int LVL_TOP = 2
) (
  input  logic signed [LVL_W-1:0] req,
  input  logic signed [LVL_W-1:0] cur,
  output logic                    same,
  output logic                    legal
);
  logic signed [LVL_W:0] diff;
  logic                  in_range;

  always_comb begin
    diff     = {req[LVL_W-1], req} - {cur[LVL_W-1], cur};
    in_range = (int'(req) >= -LVL_TOP) && (int'(req) <= LVL_TOP);
    same     = (req == cur);
    legal    = in_range && ((diff == 1) || (diff == -1));
  end
endmodule

// File: rtl/isel_combo_pick.sv
module isel_combo_pick
  import isel_pkg::*;
#(
  parameter int LVL_W = 3
) (
  input  logic signed [LVL_W-1:0] target,
  input  logic                    neg,
  output leg_code_t               code_a,
  output leg_code_t               code_b
);
  always_comb begin
    code_a = LEG_ZERO;
    code_b = LEG_ZERO;
    case (int'(target))
      2:  begin code_a = LEG_POS; code_b = LEG_POS; end
      -2: begin code_a = LEG_NEG; code_b = LEG_NEG; end
      1: begin
        if (neg) begin code_a = LEG_POS;  code_b = LEG_ZERO; end
        else     begin code_a = LEG_ZERO; code_b = LEG_POS;  end
      end
      -1: begin
        if (neg) begin code_a = LEG_ZERO; code_b = LEG_NEG;  end
        else     begin code_a = LEG_NEG;  code_b = LEG_ZERO; end
      end
      default: begin code_a = LEG_ZERO; code_b = LEG_ZERO; end
    endcase
  end
endmodule

// File: rtl/isel_effect.sv
module isel_effect
  import isel_pkg::*;
(
  input  leg_code_t   code_a,
  input  leg_code_t   code_b,
  output logic [1:0]  eff
);
  logic signed [2:0] d;
  always_comb begin
    d   = {code_a[1], code_a} - {code_b[1], code_b};
    eff = d[1:0];
  end
endmodule

// File: rtl/isel_leg_selector.sv
module isel_leg_selector
  import isel_pkg::*;
#(
  parameter int LVL_W   = 3,
  parameter int LVL_TOP = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic signed [LVL_W-1:0] lvl_req,
  input  logic                    lvl_stb,
  input  logic                    icirc_neg,
  output logic [1:0]              leg_a,
  output logic [1:0]              leg_b,
  output logic [1:0]              circ_eff,
  output logic signed [LVL_W-1:0] lvl_out,
  output logic                    step_err
);
  logic signed [LVL_W-1:0] lvl_q;
  leg_code_t               a_q, b_q, pick_a, pick_b;
  logic [1:0]              eff_q, pick_eff;
  logic                    err_q, same_lvl, step_ok;

  isel_step_chk #(.LVL_W(LVL_W), .LVL_TOP(LVL_TOP)) u_chk (
    .req(lvl_req), .cur(lvl_q), .same(same_lvl), .legal(step_ok)
  );

  isel_combo_pick #(.LVL_W(LVL_W)) u_pick (
    .target(lvl_req), .neg(icirc_neg), .code_a(pick_a), .code_b(pick_b)
  );

  isel_effect u_eff (
    .code_a(pick_a), .code_b(pick_b), .eff(pick_eff)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q <= '0;
      a_q   <= LEG_ZERO;
      b_q   <= LEG_ZERO;
      eff_q <= 2'b00;
      err_q <= 1'b0;
    end else if (lvl_stb && !same_lvl) begin
      if (step_ok) begin
        lvl_q <= lvl_req;
        a_q   <= pick_a;
        b_q   <= pick_b;
        eff_q <= pick_eff;
      end else begin
        err_q <= 1'b1;
      end
    end
  end

  assign leg_a    = a_q;
  assign leg_b    = b_q;
  assign circ_eff = eff_q;
  assign lvl_out  = lvl_q;
  assign step_err = err_q;

  // R10: at most one leg moves per clock
  p_one_leg_r10: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> !((a_q != $past(a_q)) && (b_q != $past(b_q))));

  // R5: effect never takes the excluded code
  p_eff_range_r5: assert property (@(posedge clk) disable iff (rst)
    circ_eff != 2'b10);

  // R6: same-level strobe leaves the legs alone
  p_hold_same_r6: assert property (@(posedge clk) disable iff (rst)
    (lvl_stb && same_lvl) |=> ($stable(a_q) && $stable(b_q)));

  // R7: refused request holds level and flags error
  p_bad_step_r7: assert property (@(posedge clk) disable iff (rst)
    (lvl_stb && !same_lvl && !step_ok) |=> ($stable(lvl_q) && err_q));

  // R8: error flag is sticky
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    err_q |=> err_q);

  // R4: positive current at level +1 picks the lowering combination
  p_pick_down_r4: assert property (@(posedge clk) disable iff (rst)
    (lvl_stb && step_ok && (int'(lvl_req) == 1) && !icirc_neg) |=> (circ_eff == 2'b11));
endmodule

// File: tb/isel_leg_selector_test.sv
module isel_leg_selector_test;
  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic signed [2:0] lvl_req = '0;
  logic              lvl_stb = 1'b0;
  logic              icirc_neg = 1'b0;
  logic [1:0]        leg_a, leg_b, circ_eff;
  logic signed [2:0] lvl_out;
  logic              step_err;

  int n_chk = 0;
  int n_fail = 0;
  int m_lvl, m_a, m_b;
  bit m_err;

  always #10 clk = ~clk;

  isel_leg_selector uut (
    .clk(clk), .rst(rst), .lvl_req(lvl_req), .lvl_stb(lvl_stb),
    .icirc_neg(icirc_neg), .leg_a(leg_a), .leg_b(leg_b),
    .circ_eff(circ_eff), .lvl_out(lvl_out), .step_err(step_err)
  );

  function automatic int dec(input logic [1:0] v);
    case (v)
      2'b01: return 1;
      2'b11: return -1;
      2'b00: return 0;
      default: return 99;
    endcase
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    chk({tag, " leg_a"}, dec(leg_a), m_a);
    chk({tag, " leg_b"}, dec(leg_b), m_b);
    chk("R5 effect", dec(circ_eff), m_a - m_b);
    chk("R10 level", int'(lvl_out), m_lvl);
    chk(m_err ? "R8 error" : {tag, " error"}, int'(step_err), int'(m_err));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    lvl_stb = 1'b0;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_lvl = 0; m_a = 0; m_b = 0; m_err = 1'b0;
    check_all("R1");
  endtask

  task automatic apply(input int req, input bit neg, input bit stb);
    string tag;
    int d;
    @(negedge clk);
    lvl_req = 3'(req);
    icirc_neg = neg;
    lvl_stb = stb;
    d = req - m_lvl;
    if (!stb) tag = "R9";
    else if (req == m_lvl) tag = "R6";
    else if (req < -2 || req > 2 || (d != 1 && d != -1)) tag = "R7";
    else if (req == 2 || req == -2) tag = "R2";
    else if (req == 0) tag = "R3";
    else tag = "R4";
    if (stb && req != m_lvl) begin
      if (tag == "R7") m_err = 1'b1;
      else begin
        m_lvl = req;
        case (req)
          2:  begin m_a = 1;  m_b = 1;  end
          -2: begin m_a = -1; m_b = -1; end
          1:  begin m_a = neg ? 1 : 0;  m_b = neg ? 0 : 1;   end
          -1: begin m_a = neg ? 0 : -1; m_b = neg ? -1 : 0;  end
          default: begin m_a = 0; m_b = 0; end
        endcase
      end
    end
    @(posedge clk);
    @(negedge clk);
    lvl_stb = 1'b0;
    check_all(tag);
  endtask

  initial begin
    #(20 * 200000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    for (int s = -2; s <= 2; s++) begin
      for (int r = -4; r <= 3; r++) begin
        for (int ng = 0; ng <= 1; ng++) begin
          do_reset();
          while (m_lvl != s) apply(m_lvl + ((s > m_lvl) ? 1 : -1), 1'(ng ^ 1), 1'b1);
          apply(r, 1'(ng), 1'b1);
          apply(m_lvl, 1'(ng ^ 1), 1'b1);
          apply((m_lvl < 2) ? m_lvl + 1 : m_lvl - 1, 1'(ng), 1'b1);
          apply((m_lvl < 2) ? m_lvl + 1 : m_lvl - 1, 1'(ng ^ 1), 1'b0);
          apply(-m_lvl + 3, 1'(ng), 1'b1);
          apply((m_lvl > -2) ? m_lvl - 1 : m_lvl + 1, 1'(ng), 1'b1);
        end
      end
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule